// File: doc/BRIEF.md
# Error Count Threshold Monitor

This block keeps two independent event tallies, one for correctable-error events and one for dropped auto-writeback events. Each tally is compared against a threshold that software programs. When an accepted event brings the tally to the threshold, the block sets a sticky compare flag and an interrupt pending bit for that channel. The pending bit drives the channel's interrupt output directly.

Software reaches the block through a single-cycle register port. Reads are combinational from the address. Writes take effect on the next clock edge. Word addresses are:

| Address | Register | Access |
|---|---|---|
| 0 | status | flags, write-one-to-clear |
| 1 | pending | pending bits, write-one-to-clear |
| 2 | correctable threshold | read/write |
| 3 | drop threshold | read/write |
| 4 | correctable tally | read only |
| 5 | drop tally | read only |
| 6 | control | write-only pulses, reads 0 |

Any other address reads 0. In the status, pending and control registers, bit 0 belongs to the correctable channel and bit 8 belongs to the drop channel.

Each channel runs a four-state machine:
- CH_QUIET: flag clear, pending clear.
- CH_MATCHED: flag set, pending set.
- CH_REARMED: flag clear, pending set.
- CH_ACKED: flag set, pending clear.

Its transitions are:
- *raise*: a match moves any state to CH_MATCHED.
- *flag-clear*: CH_MATCHED goes to CH_REARMED, and CH_ACKED goes to CH_QUIET.
- *pend-clear*: CH_MATCHED goes to CH_ACKED, and CH_REARMED goes to CH_QUIET.
- *both-clear*: CH_MATCHED goes to CH_QUIET.

Top module: `errcmp_ctl`

## Requirements
- R1: The status register (address 0) shows the correctable flag at bit 0 and the drop flag at bit 8. Every other bit reads 0. Writes to those other bits change nothing. After reset every register reads 0 and both interrupt outputs are 0.
- R2: An accepted event updates the tally at the clock edge. If the value reached equals the threshold, the channel's flag is set and is visible right after that same edge.
- R3: Writing 1 to a flag bit of the status register clears that flag. Writing 0 leaves it unchanged.
- R4: While a channel's flag is set, events on that channel are ignored and its tally stays unchanged.
- R5: Clearing a flag leaves the interrupt output asserted. The output drops only after 1 is written to the channel's bit in the pending register (address 1).
- R6: The pending bit is set at the same edge as the flag, and each interrupt output equals its channel's pending bit.
- R7: An accepted event that arrives while the tally already equals the threshold leaves the tally unchanged and sets the flag again. So clearing a flag without changing the threshold or the tally lets the next event re-match.
- R8: When a match and a write-one-to-clear of the same channel's pending bit fall in the same cycle, the match wins and the pending bit stays 1.
- R9: Writing 1 to a channel's bit in the control register (address 6) sets that tally to 0 at the next edge. This takes priority over an event in the same cycle.
- R10: The two channels are independent. Events, thresholds, clears and resets on one channel leave the other unchanged.
- R11: Each threshold reads back the value written to it, zero-extended, and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| ce_err_i | input | 1 | correctable-error event, one per cycle when high |
| wb_drop_i | input | 1 | dropped auto-writeback event, one per cycle when high |
| reg_addr_i | input | ADDR_W | register word address |
| reg_we_i | input | 1 | write enable |
| reg_wdata_i | input | DATA_W | write data |
| reg_rdata_o | output | DATA_W | read data for reg_addr_i |
| ce_irq_o | output | 1 | correctable channel interrupt request |
| wb_drop_irq_o | output | 1 | drop channel interrupt request |

## Verification
Some properties are checked by the assertions on every cycle:
- the frozen tally while a flag is set;
- the control-register reset of a tally;
- a match raising both flag and pending bit;
- flag and pending persistence until a one is written;
- a match beating a same-cycle pending clear;
- reserved status bits reading zero.

Other behaviour is shown only by the bench scenarios: exact tally values, re-matching after a bare flag clear, reset priority over a simultaneous event, and the isolation between the two channels.

// File: rtl/errcmp_pkg.sv
package errcmp_pkg;

    // Bit 1 of the encoding is the flag, bit 0 is the pending bit.
    typedef enum logic [1:0] {
        CH_QUIET   = 2'b00,
        CH_REARMED = 2'b01,
        CH_ACKED   = 2'b10,
        CH_MATCHED = 2'b11
    } ch_state_e;

    localparam int NUM_CH     = 2;
    localparam int BIT_STRIDE = 8;

    localparam int A_STATUS   = 0;
    localparam int A_PEND     = 1;
    localparam int A_THR_BASE = 2;
    localparam int A_CNT_BASE = 4;
    localparam int A_CTRL     = 6;

endpackage

// File: rtl/errcmp_counter.sv
module errcmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_i,
    input  logic             hold_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             accept;
    logic             at_thr;

    assign accept  = evt_i && !hold_i && !clr_i;
    assign at_thr  = (cnt_q == thr_i);
    assign cnt_nxt = at_thr ? cnt_q : cnt_q + CNT_W'(1);
    assign match_o = accept && (cnt_nxt == thr_i);
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= cnt_nxt;
        end
    end

    AST_FROZEN_WHEN_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i && !clr_i) |=> $stable(cnt_q)); // R4
    AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/errcmp_fsm.sv
module errcmp_fsm
    import errcmp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic match_i,
    input  logic clr_flag_i,
    input  logic clr_pend_i,
    output logic flag_o,
    output logic pend_o
);
    ch_state_e state_q;
    ch_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_QUIET: begin
                if (match_i) state_d = CH_MATCHED;
            end
            CH_MATCHED: begin
                if (match_i)                      state_d = CH_MATCHED;
                else if (clr_flag_i && clr_pend_i) state_d = CH_QUIET;
                else if (clr_flag_i)              state_d = CH_REARMED;
                else if (clr_pend_i)              state_d = CH_ACKED;
            end
            CH_REARMED: begin
                if (match_i)         state_d = CH_MATCHED;
                else if (clr_pend_i) state_d = CH_QUIET;
            end
            CH_ACKED: begin
                if (match_i)         state_d = CH_MATCHED;
                else if (clr_flag_i) state_d = CH_QUIET;
            end
            default: state_d = CH_QUIET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CH_QUIET;
        else         state_q <= state_d;
    end

    always_comb begin
        flag_o = 1'b0;
        pend_o = 1'b0;
        unique case (state_q)
            CH_QUIET:   begin flag_o = 1'b0; pend_o = 1'b0; end
            CH_REARMED: begin flag_o = 1'b0; pend_o = 1'b1; end
            CH_ACKED:   begin flag_o = 1'b1; pend_o = 1'b0; end
            CH_MATCHED: begin flag_o = 1'b1; pend_o = 1'b1; end
            default:    begin flag_o = 1'b0; pend_o = 1'b0; end
        endcase
    end

    AST_MATCH_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_i |=> (flag_o && pend_o)); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !clr_flag_i) |=> flag_o); // R3
    AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !clr_pend_i) |=> pend_o); // R5
    AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_i && clr_pend_i) |=> pend_o); // R8

endmodule

// File: rtl/errcmp_ctl.sv
module errcmp_ctl
    import errcmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_err_i,
    input  logic              wb_drop_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              ce_irq_o,
    output logic              wb_drop_irq_o
);
    localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(A_STATUS);
    localparam logic [ADDR_W-1:0] ADR_PEND   = ADDR_W'(A_PEND);
    localparam logic [ADDR_W-1:0] ADR_CTRL   = ADDR_W'(A_CTRL);

    logic [NUM_CH-1:0] evt;
    logic [NUM_CH-1:0] flag;
    logic [NUM_CH-1:0] pend;
    logic [CNT_W-1:0]  thr_q [NUM_CH];
    logic [CNT_W-1:0]  cnt   [NUM_CH];
    logic [DATA_W-1:0] status_mask;
    logic              wdata_unused;

    assign evt          = {wb_drop_i, ce_err_i};
    assign wdata_unused = ^reg_wdata_i;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int                BITPOS   = ch * BIT_STRIDE;
        localparam logic [ADDR_W-1:0] ADR_THR  = ADDR_W'(A_THR_BASE + ch);

        logic clr_flag;
        logic clr_pend;
        logic clr_cnt;
        logic match;

        assign clr_flag = reg_we_i && (reg_addr_i == ADR_STATUS) && reg_wdata_i[BITPOS];
        assign clr_pend = reg_we_i && (reg_addr_i == ADR_PEND)   && reg_wdata_i[BITPOS];
        assign clr_cnt  = reg_we_i && (reg_addr_i == ADR_CTRL)   && reg_wdata_i[BITPOS];

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                thr_q[ch] <= '0;
            end else if (reg_we_i && (reg_addr_i == ADR_THR)) begin
                thr_q[ch] <= reg_wdata_i[CNT_W-1:0];
            end
        end

        errcmp_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .evt_i   (evt[ch]),
            .hold_i  (flag[ch]),
            .clr_i   (clr_cnt),
            .thr_i   (thr_q[ch]),
            .cnt_o   (cnt[ch]),
            .match_o (match)
        );

        errcmp_fsm u_fsm (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .match_i    (match),
            .clr_flag_i (clr_flag),
            .clr_pend_i (clr_pend),
            .flag_o     (flag[ch]),
            .pend_o     (pend[ch])
        );
    end

    always_comb begin
        status_mask = '0;
        for (int c = 0; c < NUM_CH; c++) status_mask[c*BIT_STRIDE] = 1'b1;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADR_STATUS) begin
            for (int c = 0; c < NUM_CH; c++) reg_rdata_o[c*BIT_STRIDE] = flag[c];
        end else if (reg_addr_i == ADR_PEND) begin
            for (int c = 0; c < NUM_CH; c++) reg_rdata_o[c*BIT_STRIDE] = pend[c];
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (reg_addr_i == ADDR_W'(A_THR_BASE + c)) reg_rdata_o = DATA_W'(thr_q[c]);
                if (reg_addr_i == ADDR_W'(A_CNT_BASE + c)) reg_rdata_o = DATA_W'(cnt[c]);
            end
        end
    end

    assign ce_irq_o      = pend[0];
    assign wb_drop_irq_o = pend[1];

    AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == ADR_STATUS) |-> ((reg_rdata_o & ~status_mask) == '0)); // R1

endmodule

// File: tb/tb_errcmp_ctl.sv
`timescale 1ns/1ps
module tb_errcmp_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_err = 1'b0;
    logic        wb_drop = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ce_irq;
    logic        drop_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    errcmp_ctl dut (
        .clk_i(clk), .rst_ni(rst_n), .ce_err_i(ce_err), .wb_drop_i(wb_drop),
        .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .ce_irq_o(ce_irq), .wb_drop_irq_o(drop_irq)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CE = 2'd2, OP_DR = 2'd3;
    localparam logic [3:0] STS = 4'd0, PND = 4'd1, THC = 4'd2, THD = 4'd3,
                           CNC = 4'd4, CND = 4'd5, CTL = 4'd6;
    localparam logic [31:0] Z = 32'h0;
    localparam int NV = 36;
    // op, addr, data, expected read value
    localparam logic [69:0] VEC [0:NV-1] = '{
        {OP_RD, STS, Z, 32'h0},             // R1 reset
        {OP_WR, THC, 32'h3, Z},
        {OP_RD, THC, Z, 32'h3},             // R11
        {OP_CE, STS, Z, Z},
        {OP_CE, STS, Z, Z},
        {OP_RD, CNC, Z, 32'h2},             // R2 count
        {OP_RD, STS, Z, 32'h0},             // R2 no early match
        {OP_CE, STS, Z, Z},
        {OP_RD, STS, Z, 32'h1},             // R2 match
        {OP_RD, PND, Z, 32'h1},             // R6
        {OP_CE, STS, Z, Z},
        {OP_RD, CNC, Z, 32'h3},             // R4 frozen
        {OP_WR, STS, 32'h0, Z},
        {OP_RD, STS, Z, 32'h1},             // R3 zero write
        {OP_WR, STS, 32'h1, Z},
        {OP_RD, STS, Z, 32'h0},             // R3 clear
        {OP_RD, PND, Z, 32'h1},             // R5 pending kept
        {OP_CE, STS, Z, Z},
        {OP_RD, STS, Z, 32'h1},             // R7 re-match
        {OP_RD, CNC, Z, 32'h3},             // R7 tally held
        {OP_WR, STS, 32'h1, Z},
        {OP_WR, PND, 32'h1, Z},
        {OP_RD, PND, Z, 32'h0},             // R5 pending cleared
        {OP_RD, STS, Z, 32'h0},
        {OP_WR, THD, 32'h2, Z},
        {OP_RD, THD, Z, 32'h2},             // R11
        {OP_DR, STS, Z, Z},
        {OP_DR, STS, Z, Z},
        {OP_RD, STS, Z, 32'h100},           // R10 drop flag bit 8
        {OP_RD, CNC, Z, 32'h3},             // R10 other tally intact
        {OP_WR, STS, 32'hFFFF_FEFE, Z},
        {OP_RD, STS, Z, 32'h100},           // R1 reserved write ignored
        {OP_WR, CTL, 32'h1, Z},
        {OP_RD, CNC, Z, 32'h0},             // R9 reset tally
        {OP_RD, CND, Z, 32'h2},             // R10 drop tally intact
        {OP_RD, 4'd7, Z, 32'h0}             // R1 unmapped reads zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic ce, input logic dr);
        we = w; addr = a; wdata = d; ce_err = ce; wb_drop = dr;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0; ce_err = 1'b0; wb_drop = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ce_irq", {31'b0, ce_irq}, 32'h0);
        check("R1 reset drop_irq", {31'b0, drop_irq}, 32'h0);
        for (int i = 0; i < 7; i++) rd("R1 R11 reset regs", 4'(i), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  a;
            logic [31:0] d;
            logic [31:0] e;
            {op, a, d, e} = VEC[i];
            unique case (op)
                OP_WR: cyc(1'b1, a, d, 1'b0, 1'b0);
                OP_RD: rd($sformatf("table step %0d", i), a, e);
                OP_CE: cyc(1'b0, a, Z, 1'b1, 1'b0);
                OP_DR: cyc(1'b0, a, Z, 1'b0, 1'b1);
                default: ;
            endcase
        end

        // R9: reset beats a same-cycle event
        cyc(1'b1, CTL, 32'h1, 1'b1, 1'b0);
        rd("R9 reset priority", CNC, 32'h0);

        // R6: irq rises with the flag
        cyc(1'b1, THC, 32'h1, 1'b0, 1'b0);
        cyc(1'b0, STS, Z, 1'b1, 1'b0);
        check("R6 irq with flag", {31'b0, ce_irq}, 32'h1);
        rd("R2 flag thr1", STS, 32'h101);

        // R5: flag clear keeps irq
        cyc(1'b1, STS, 32'h1, 1'b0, 1'b0);
        check("R5 irq after flag clear", {31'b0, ce_irq}, 32'h1);
        rd("R5 flag cleared", STS, 32'h100);

        // R8: match with same-cycle pending clear
        cyc(1'b1, PND, 32'h1, 1'b1, 1'b0);
        check("R8 irq kept", {31'b0, ce_irq}, 32'h1);
        rd("R8 pending kept", PND, 32'h101);
        rd("R7 R8 flag set", STS, 32'h101);

        cyc(1'b1, STS, 32'h1, 1'b0, 1'b0);
        cyc(1'b1, PND, 32'h1, 1'b0, 1'b0);
        check("R5 irq cleared", {31'b0, ce_irq}, 32'h0);
        check("R10 drop irq intact", {31'b0, drop_irq}, 32'h1);

        summary();
    end
endmodule